// File: doc/BRIEF.md
# I2C Sub-Address Bus Trigger

A passive observer for a two-wire I2C bus. It samples the clock and data lines through synchronizers in its own system clock domain, finds START, repeated START and STOP conditions, and decodes each frame: the 7-bit device address, the read/write bit, and then the data bytes in order. A single byte position of the frame, chosen by an index, is compared against a programmed criterion. When the address, the direction and that byte all qualify, the block raises a trigger pulse one system clock wide.

The usual target is a memory-style slave whose first written data byte is an internal pointer (a sub-address). The comparison is either a bit pattern with don't-care positions, which catches a block of addresses aligned on upper bits, or an inclusive lower/upper range, which catches a block that is not aligned. An exact value is a pattern with every bit compared.

The block has no streaming interface. The trigger is a plain pulse with no handshake. There is nothing to back-pressure, and the block never drives either bus line. Configuration inputs are static levels that are expected to stay steady while a frame is in flight. The system clock must run at least 8 times the bus clock rate.

Top module: `i2c_subaddr_trigger`

## Requirements
- R1: After reset, `trig_o` is 0. A bus that stays idle (both lines high) never raises it.
- R2: The address byte qualifies only when, for every bit of `cfg_addr_care` that is 1, the received 7-bit address equals `cfg_addr_pat` in that bit. A 0 in `cfg_addr_care` marks a don't-care bit. A frame whose address does not qualify produces no trigger, whatever bytes follow it.
- R3: The read/write bit (bit 0 of the address byte, 0 = write, 1 = read) must equal `cfg_dir`, or the frame produces no trigger.
- R4: Only the data byte at position `cfg_byte_idx` is compared, where 0 is the first byte after the address byte. Bytes at other positions have no effect.
- R5: With `cfg_mode` = 0 (pattern mode), the selected byte matches when it equals `cfg_data_pat` in every bit where `cfg_data_care` is 1.
- R6: With `cfg_mode` = 1 (range mode), the selected byte matches when `cfg_lo` <= byte <= `cfg_hi`, both bounds inclusive and compared unsigned.
- R7: A START or repeated START resets the byte position to the address byte. Decoding restarts there with no STOP needed in between.
- R8: `trig_o` is a pulse exactly one clock wide. It fires at most once per frame, during the acknowledge clock of the compared byte.
- R9: A frame that ends (STOP or repeated START) before it reaches position `cfg_byte_idx` produces no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| cfg_addr_pat | input | 7 | Device address pattern |
| cfg_addr_care | input | 7 | Address bit compare enables (1 = compare) |
| cfg_dir | input | 1 | Required read/write bit (0 write, 1 read) |
| cfg_byte_idx | input | IDX_W | Data byte position compared (0 = first) |
| cfg_mode | input | 1 | 0 pattern mode, 1 range mode |
| cfg_data_pat | input | 8 | Data pattern for pattern mode |
| cfg_data_care | input | 8 | Data bit compare enables (1 = compare) |
| cfg_lo | input | 8 | Inclusive lower bound for range mode |
| cfg_hi | input | 8 | Inclusive upper bound for range mode |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench sends every one of the 256 values of the first data byte twice. The first sweep uses pattern mode with an aligned block (0x48 to 0x4F), which shows that only the care bits decide the match. The second uses range mode with an unaligned window (0x16 to 0x1D), which exposes off-by-one errors at both inclusive bounds. It also sends all 128 device addresses against a four-bit address pattern, and read frames under both direction settings. Multi-byte frames place the matching value at, before and after the selected index, or stop short of it. Repeated-START sequences show that decoding restarts without a STOP and that a match fires only once per frame.

// File: rtl/i2c_trig_pkg.sv
package i2c_trig_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic {
    MODE_PATTERN = 1'b0,
    MODE_RANGE   = 1'b1
  } match_mode_e;

  function automatic logic addr_hit(input logic [ADDR_W-1:0] rx,
                                    input logic [ADDR_W-1:0] pat,
                                    input logic [ADDR_W-1:0] care);
    return ((rx ^ pat) & care) == '0;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_s
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] scl_ch;
  logic [CHAIN-1:0] sda_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch <= '1;
      sda_ch <= '1;
    end else begin
      scl_ch <= {scl_ch[CHAIN-2:0], scl_i};
      sda_ch <= {sda_ch[CHAIN-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now  = scl_ch[CHAIN-2];
  assign scl_old  = scl_ch[CHAIN-1];
  assign sda_now  = sda_ch[CHAIN-2];
  assign sda_old  = sda_ch[CHAIN-1];

  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_now;

  // R7: a START and a STOP can never be seen in the same cycle
  assert_no_start_stop_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
endmodule

// File: rtl/i2c_frame_decoder.sv
module i2c_frame_decoder
  import i2c_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  output logic              byte_ev,
  output logic              byte_is_addr,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic              in_frame;
  logic              first_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      first_q  <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (start_ev) begin
      in_frame <= 1'b1;
      first_q  <= 1'b1;
      bit_cnt  <= '0;
    end else if (stop_ev) begin
      in_frame <= 1'b0;
    end else if (scl_rise && in_frame) begin
      if (bit_cnt == ACK_SLOT) begin
        bit_cnt <= '0;
        first_q <= 1'b0;
      end else begin
        shreg   <= {shreg[BYTE_W-2:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign byte_ev      = scl_rise && in_frame && (bit_cnt == ACK_SLOT) && !start_ev && !stop_ev;
  assign byte_is_addr = first_q;
  assign byte_val     = shreg;

  // R8: bit position never runs past the acknowledge slot
  assert_bitcnt_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= ACK_SLOT);
  // R7: a START puts the decoder back on the address byte
  assert_start_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bit_cnt == '0) && first_q);
endmodule

// File: rtl/i2c_byte_matcher.sv
module i2c_byte_matcher
  import i2c_trig_pkg::*;
(
  input  logic              mode,
  input  logic [BYTE_W-1:0] rx,
  input  logic [BYTE_W-1:0] pat,
  input  logic [BYTE_W-1:0] care,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  output logic              hit
);
  logic pat_hit, rng_hit;

  assign pat_hit = ((rx ^ pat) & care) == '0;
  assign rng_hit = (rx >= lo) && (rx <= hi);

  always_comb begin
    unique case (match_mode_e'(mode))
      MODE_RANGE: hit = rng_hit;
      default:    hit = pat_hit;
    endcase
  end
endmodule

// File: rtl/i2c_subaddr_trigger.sv
module i2c_subaddr_trigger
  import i2c_trig_pkg::*;
#(
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [6:0]       cfg_addr_pat,
  input  logic [6:0]       cfg_addr_care,
  input  logic             cfg_dir,
  input  logic [IDX_W-1:0] cfg_byte_idx,
  input  logic             cfg_mode,
  input  logic [7:0]       cfg_data_pat,
  input  logic [7:0]       cfg_data_care,
  input  logic [7:0]       cfg_lo,
  input  logic [7:0]       cfg_hi,
  output logic             trig_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic scl_rise, start_ev, stop_ev, sda_s;
  logic byte_ev, byte_is_addr;
  logic [BYTE_W-1:0] byte_val;
  logic data_hit;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s)
  );

  i2c_frame_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_s(sda_s), .byte_ev(byte_ev),
    .byte_is_addr(byte_is_addr), .byte_val(byte_val)
  );

  i2c_byte_matcher u_match (
    .mode(cfg_mode), .rx(byte_val), .pat(cfg_data_pat), .care(cfg_data_care),
    .lo(cfg_lo), .hi(cfg_hi), .hit(data_hit)
  );

  logic             live;
  logic [IDX_W-1:0] pos;
  logic             addr_ok;

  assign addr_ok = addr_hit(byte_val[7:1], cfg_addr_pat, cfg_addr_care) &&
                   (byte_val[0] == cfg_dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      pos    <= '0;
      trig_o <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (start_ev) begin
        live <= 1'b1;
        pos  <= '0;
      end else if (stop_ev) begin
        live <= 1'b0;
      end else if (byte_ev && live) begin
        if (byte_is_addr) begin
          live <= addr_ok;
        end else if (pos == cfg_byte_idx) begin
          trig_o <= data_hit;
          live   <= 1'b0;
        end else if (pos != IDX_MAX) begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  // R8: the trigger is a single-cycle pulse
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);
  // R8: a pulse only follows an acknowledge clock
  assert_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(byte_ev));
  // R7: every START clears the byte position
  assert_pos_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (pos == '0));
  // R1: an idle bus cannot fire
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !trig_o);
endmodule

// File: tb/i2c_subaddr_trigger_tb.sv
module i2c_subaddr_trigger_tb;
  localparam int IDX_W = 4;
  localparam int Q = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [6:0] cfg_addr_pat = 7'b1010000, cfg_addr_care = 7'b1111000;
  logic cfg_dir = 1'b0;
  logic [IDX_W-1:0] cfg_byte_idx = '0;
  logic cfg_mode = 1'b0;
  logic [7:0] cfg_data_pat = 8'h48, cfg_data_care = 8'hF8;
  logic [7:0] cfg_lo = 8'h16, cfg_hi = 8'h1D;
  logic trig;

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic [7:0] fb [8];

  always #4 clk = ~clk;

  i2c_subaddr_trigger #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .cfg_addr_pat(cfg_addr_pat), .cfg_addr_care(cfg_addr_care), .cfg_dir(cfg_dir),
    .cfg_byte_idx(cfg_byte_idx), .cfg_mode(cfg_mode), .cfg_data_pat(cfg_data_pat),
    .cfg_data_care(cfg_data_care), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .trig_o(trig)
  );

  always @(negedge clk) if (trig) pulses++;

  task automatic wq(input int n); repeat (n) @(posedge clk); endtask

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_start(); sda = 1'b0; wq(2*Q); scl = 1'b0; wq(Q); endtask
  task automatic bus_rstart();
    sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bus_stop();
    sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda = 1'b1; wq(3*Q);
  endtask
  task automatic bus_bit(input logic b);
    sda = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bus_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(1'b0);
  endtask

  // one frame: address, direction, n data bytes from fb
  task automatic frame(input logic [6:0] a, input logic rw, input int n);
    bus_start();
    bus_byte({a, rw});
    for (int i = 0; i < n; i++) bus_byte(fb[i]);
  endtask

  task automatic run_frame(input logic [6:0] a, input logic rw, input int n,
                           input int exp, input string tag);
    pulses = 0;
    frame(a, rw, n);
    bus_stop();
    wq(4);
    check(pulses, exp, tag);
  endtask

  int watchdog_hit = 0;
  initial begin
    repeat (190000) @(posedge clk);
    watchdog_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wq(3);
    @(negedge clk); check(int'(trig), 0, "R1 reset");
    rst_n = 1'b1;
    wq(20);
    check(pulses, 0, "R1 idle bus");

    // R5 pattern mode, aligned block 0x48..0x4F
    for (int v = 0; v < 256; v++) begin
      fb[0] = 8'(v);
      run_frame(7'h50, 1'b0, 1, ((v & 8'hF8) == 8'h48) ? 1 : 0, "R5 pattern sweep");
    end
    // R5 exact value
    cfg_data_pat = 8'h20; cfg_data_care = 8'hFF;
    for (int v = 8'h1E; v <= 8'h22; v++) begin
      fb[0] = 8'(v);
      run_frame(7'h53, 1'b0, 1, (v == 8'h20) ? 1 : 0, "R5 exact");
    end

    // R6 range mode, unaligned window
    cfg_mode = 1'b1;
    for (int v = 0; v < 256; v++) begin
      fb[0] = 8'(v);
      run_frame(7'h57, 1'b0, 1, (v >= 8'h16 && v <= 8'h1D) ? 1 : 0, "R6 range sweep");
    end

    // R2 all addresses
    fb[0] = 8'h18;
    for (int a = 0; a < 128; a++)
      run_frame(7'(a), 1'b0, 1, ((a >> 3) == 4'b1010) ? 1 : 0, "R2 address sweep");

    // R3 direction
    run_frame(7'h50, 1'b1, 1, 0, "R3 read vs write cfg");
    cfg_dir = 1'b1;
    run_frame(7'h50, 1'b1, 1, 1, "R3 read vs read cfg");
    run_frame(7'h50, 1'b0, 1, 0, "R3 write vs read cfg");
    cfg_dir = 1'b0;

    // R4 byte index
    cfg_byte_idx = 4'd2;
    fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h18; fb[3] = 8'h00;
    run_frame(7'h50, 1'b0, 4, 1, "R4 hit at index 2");
    fb[0] = 8'h18; fb[1] = 8'h18; fb[2] = 8'h00; fb[3] = 8'h18;
    run_frame(7'h50, 1'b0, 4, 0, "R4 hits off index");

    // R9 frame shorter than index
    cfg_byte_idx = 4'd3;
    fb[0] = 8'h18; fb[1] = 8'h18;
    run_frame(7'h50, 1'b0, 2, 0, "R9 short frame");

    // R8 once per frame
    cfg_byte_idx = 4'd0;
    fb[0] = 8'h18; fb[1] = 8'h18; fb[2] = 8'h18; fb[3] = 8'h18;
    run_frame(7'h50, 1'b0, 4, 1, "R8 single fire");

    // R7 repeated start: write sub-address then read, no STOP between
    pulses = 0;
    fb[0] = 8'h19;
    frame(7'h50, 1'b0, 1);
    bus_rstart();
    bus_byte({7'h50, 1'b1});
    bus_byte(8'hAA);
    bus_stop(); wq(4);
    check(pulses, 1, "R7 write then read");

    // R7 / R9: byte position restarts on repeated START
    cfg_byte_idx = 4'd1;
    pulses = 0;
    fb[0] = 8'h99;
    frame(7'h50, 1'b0, 1);
    bus_rstart();
    bus_byte({7'h50, 1'b0});
    bus_byte(8'h00);
    bus_byte(8'h18);
    bus_stop(); wq(4);
    check(pulses, 1, "R7 restart count");

    if (!watchdog_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule